// File: doc/BRIEF.md
# Clock-Fraction Calculator with Clamping

This block does the arithmetic for a fractional clock divider whose output runs at parent × 18 / fraction. In forward mode it takes a parent frequency and a wanted output frequency. It returns the 6-bit fraction to program, rounded to the nearest value and held within 12 to 35. It also returns the output frequency that this fraction actually gives. In reverse mode it takes a parent frequency and a fraction, and returns the output frequency that results, truncated.

A single restoring divider does both divisions, producing one quotient bit per clock. A forward request therefore runs two divisions back to back. A reverse request runs one. A request is accepted on a `start` pulse while the unit is idle. The results are presented with a one-cycle `done` pulse and are held until the next accepted request. A zero divisor is reported through `err` and no division is run.

Top module: `clk_frac_calc`

## Requirements
- R1: In forward mode (`mode`=0), when Q = floor((parent·18 + floor(target/2)) / target) lies in 12..35, `frac_out` equals Q.
- R2: In forward mode, when Q is below 12, `frac_out` is 12.
- R3: In forward mode, when Q is above 35, `frac_out` is 35, even for quotients far beyond 6 bits.
- R4: In forward mode, `freq_out` equals floor(parent·18 / `frac_out`), computed at full 40-bit width.
- R5: In reverse mode (`mode`=1), `freq_out` equals floor(parent·18 / frac_in) for any frac_in 1..63, with no rounding and no clamping. `frac_out` echoes frac_in.
- R6: A request with target 0 in forward mode, or with frac_in 0 in reverse mode, raises `done` and `err` at the accepting edge and sets both results to 0. Any successful request clears `err`.
- R7: Counting the edge that accepts `start` as edge 1, `done` rises after edge 83 in forward mode and after edge 42 in reverse mode. `done` stays high for exactly one cycle. `busy` is high from the accepting edge until `done` rises.
- R8: A `start` pulse while `busy` is high is ignored. The running request finishes with its own operands and no second `done` follows.
- R9: After reset, `busy`, `done` and `err` are low and both results are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only while idle |
| mode | input | 1 | 0 = forward (frequency to fraction), 1 = reverse (fraction to frequency) |
| parent | input | 32 | Parent frequency |
| target | input | 32 | Wanted output frequency (forward mode) |
| frac_in | input | 6 | Fraction (reverse mode) |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Last request had a zero divisor |
| frac_out | output | 6 | Clamped fraction (forward) or echoed fraction (reverse) |
| freq_out | output | 40 | Resulting output frequency |

## Verification
A corrupted remainder, shift or iteration count in the divider shows up as a wrong `freq_out` or `frac_out` at the same `done` pulse that ends the faulty request. A wrong iteration count also shifts `done` away from edge 42 or 83, which the bench checks on every request. Faults in the clamp show up only on forward requests near a fraction edge. For that reason the bench aims wanted frequencies at parent·18/f ± 1 for every f from 10 to 37. A faulty idle guard shows up as a changed result or an extra `done` within one request time of the ignored pulse.

// File: rtl/clk_frac_calc.sv
module clk_frac_calc #(
  parameter int FW    = 32,
  parameter int PW    = 40,
  parameter int FRW   = 6,
  parameter int SCALE = 18,
  parameter int FMIN  = 12,
  parameter int FMAX  = 35
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           mode,
  input  logic [FW-1:0]  parent,
  input  logic [FW-1:0]  target,
  input  logic [FRW-1:0] frac_in,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [FRW-1:0] frac_out,
  output logic [PW-1:0]  freq_out
);
  localparam int CW = $clog2(PW);
  localparam logic [CW-1:0] LAST = CW'(PW - 1);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_NEXT} state_t;
  state_t state;

  logic           mode_r, phase2;
  logic [PW-1:0]  quo, prod_r;
  logic [FW:0]    rem;
  logic [FW-1:0]  dvs;
  logic [CW-1:0]  cnt;

  wire [PW-1:0]  prod    = PW'(parent) * PW'(SCALE);
  wire [PW-1:0]  fwd_num = prod + PW'(target >> 1);
  wire           zero_in = mode ? (frac_in == '0) : (target == '0);
  wire [FW:0]    shifted = {rem[FW-1:0], quo[PW-1]};
  wire           ge      = shifted >= {1'b0, dvs};
  wire [FW:0]    diff    = shifted - {1'b0, dvs};
  wire [FRW-1:0] frac_cl = (quo > PW'(FMAX)) ? FRW'(FMAX) :
                           (quo < PW'(FMIN)) ? FRW'(FMIN) : quo[FRW-1:0];

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mode_r   <= 1'b0;
      phase2   <= 1'b0;
      quo      <= '0;
      prod_r   <= '0;
      rem      <= '0;
      dvs      <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      frac_out <= '0;
      freq_out <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          mode_r <= mode;
          prod_r <= prod;
          phase2 <= 1'b0;
          rem    <= '0;
          cnt    <= LAST;
          if (zero_in) begin
            done     <= 1'b1;
            err      <= 1'b1;
            frac_out <= '0;
            freq_out <= '0;
          end else begin
            quo   <= mode ? prod : fwd_num;
            dvs   <= mode ? FW'(frac_in) : target;
            state <= S_DIV;
          end
        end
        S_DIV: begin
          rem <= ge ? diff : shifted;
          quo <= {quo[PW-2:0], ge};
          cnt <= cnt - 1'b1;
          if (cnt == '0) state <= S_NEXT;
        end
        S_NEXT: begin
          if (!mode_r && !phase2) begin
            phase2 <= 1'b1;
            quo    <= prod_r;
            dvs    <= FW'(frac_cl);
            rem    <= '0;
            cnt    <= LAST;
            state  <= S_DIV;
          end else begin
            freq_out <= quo;
            frac_out <= dvs[FRW-1:0];
            err      <= 1'b0;
            done     <= 1'b1;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [7:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (!busy) busy_run <= '0;
    else if (busy_run != 8'hFF) busy_run <= busy_run + 1'b1;
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r7_bounded_run: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run <= 8'(2 * PW + 2)));
  a_r3_frac_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && !mode_r) |-> (frac_out >= FRW'(FMIN) && frac_out <= FRW'(FMAX)));
  a_r6_zero_err: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && zero_in) |=> (done && err && freq_out == '0));
  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !zero_in) |=> (busy && !done));
endmodule

// File: tb/clk_frac_calc_test.sv
module clk_frac_calc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [31:0] parent = '0;
  logic [31:0] target = '0;
  logic [5:0]  frac_in = '0;
  logic        busy, done, err;
  logic [5:0]  frac_out;
  logic [39:0] freq_out;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  clk_frac_calc uut (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .parent(parent), .target(target), .frac_in(frac_in), .busy(busy),
    .done(done), .err(err), .frac_out(frac_out), .freq_out(freq_out));

  always #2 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 190000", cyc);
      summary();
    end
  end

  task automatic chk(input string rq, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic run(input logic m, input logic [31:0] p, input logic [31:0] t,
                     input logic [5:0] f, output int lat, output logic b1);
    @(negedge clk);
    mode = m; parent = p; target = t; frac_in = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1; b1 = busy;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_rev(input logic [31:0] p, input logic [5:0] f);
    int lat; logic b1;
    longint p18 = longint'(p) * 18;
    run(1'b1, p, 32'd0, f, lat, b1);
    if (f == 0) begin
      chk("R6 err", err, 1);
      chk("R6 latency", lat, 1);
      chk("R6 freq", freq_out, 0);
    end else begin
      chk("R5 freq", freq_out, p18 / f);
      chk("R5 frac echo", frac_out, f);
      chk("R6 err cleared", err, 0);
      chk("R7 latency rev", lat, 42);
      chk("R7 busy", b1, 1);
    end
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
  endtask

  task automatic check_fwd(input logic [31:0] p, input logic [31:0] t);
    int lat; logic b1;
    longint p18 = longint'(p) * 18;
    longint q, fc;
    string rq;
    run(1'b0, p, t, 6'd0, lat, b1);
    if (t == 0) begin
      chk("R6 err", err, 1);
      chk("R6 latency", lat, 1);
      chk("R6 frac", frac_out, 0);
    end else begin
      q = (p18 + longint'(t / 2)) / longint'(t);
      if (q < 12) begin fc = 12; rq = "R2 clamp low"; end
      else if (q > 35) begin fc = 35; rq = "R3 clamp high"; end
      else begin fc = q; rq = "R1 round"; end
      chk(rq, frac_out, fc);
      chk("R4 achieved freq", freq_out, p18 / fc);
      chk("R6 err cleared", err, 0);
      chk("R7 latency fwd", lat, 83);
      chk("R7 busy", b1, 1);
    end
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
  endtask

  logic [31:0] parents [4] = '{32'd1, 32'd24000000, 32'd528000000, 32'hFFFFFFFF};

  initial begin
    #1;
    chk("R9 busy", busy, 0);
    chk("R9 done", done, 0);
    chk("R9 err", err, 0);
    chk("R9 frac", frac_out, 0);
    chk("R9 freq", freq_out, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", busy, 0);

    foreach (parents[i]) begin
      for (int f = 0; f < 64; f++) check_rev(parents[i], 6'(f));
    end

    foreach (parents[i]) begin
      longint p18 = longint'(parents[i]) * 18;
      check_fwd(parents[i], 32'd0);
      check_fwd(parents[i], 32'd1);
      check_fwd(parents[i], 32'hFFFFFFFF);
      for (int f = 10; f <= 37; f++) begin
        for (int d = -1; d <= 1; d++) begin
          longint t = p18 / f + d;
          if (t > 0 && t <= 64'hFFFFFFFF) check_fwd(parents[i], 32'(t));
        end
      end
    end

    begin
      int lat;
      int extra = 0;
      @(negedge clk);
      mode = 1'b1; parent = 32'd1000; frac_in = 6'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      mode = 1'b0; parent = 32'd5; target = 32'd3; frac_in = 6'd50; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 6;
      while (!done && lat < 200) begin @(negedge clk); lat++; end
      chk("R8 first result kept", freq_out, 18000 / 7);
      chk("R8 frac kept", frac_out, 7);
      chk("R8 latency unchanged", lat, 42);
      repeat (100) begin @(negedge clk); if (done) extra++; end
      chk("R8 no second done", extra, 0);
    end

    finished = 1;
    summary();
  end
endmodule